// File: doc/BRIEF.md
# Two-Stage Expiry Watchdog Timer

This block is a countdown watchdog that escalates in two steps. A down counter moves one step on each tick-enable pulse. When it runs out the first time, the block raises an expiry flag and reloads itself. If an interrupt-enable bit is set, it also sends a one-cycle request to the system-management interrupt handler. That handler, or software, can acknowledge the expiry by writing a one to the flag. If the counter runs out again while the flag is still raised, the block sends a one-cycle system reset pulse instead, and the expiry history is cleared.

A keepalive strobe reloads the counter and also clears the flag. The reload value comes from a period register, and a period of zero counts as one tick. The time from a missed keepalive to reset is therefore between just over one period and about two periods, depending on when the flag was last cleared. Three registers are reached over a simple read/write bus: the interrupt control word, the status word holding the flag, and the period. The tick input lets a test use a short period with a fast clock.

Top module: `twostage_wdt`

## Requirements
- R1: After reset: the expiry flag is clear, the interrupt-enable bit (bit 13 of the control word at address 0x30) reads back as `SMI_EN_RST`, the period register (address 0x68) reads `PERIOD_RST`, and both `smi_req_o` and `sys_rst_o` are low.
- R2: An expiry happens on the tick that completes exactly max(P,1) ticks since the last reload, where P is the period used at that reload. Cycles with `tick_i` low do not advance the count.
- R3: The first expiry sets the flag at bit 3 of the status word (address 0x64) and reloads the counter.
- R4: On a first expiry, `smi_req_o` pulses high for one cycle only if the interrupt-enable bit is 1. When the bit is 0, no request is made, but the flag is still set.
- R5: An expiry while the flag is set drives `sys_rst_o` high for exactly one cycle and leaves the flag clear. It makes no interrupt request.
- R6: A write to the status word with bit 3 set clears the flag. A write with bit 3 clear has no effect. All other status bits read as zero.
- R7: A `kick_i` pulse reloads the counter and clears the flag. A kick in the same cycle as a tick takes priority, and no expiry happens in that cycle.
- R8: Clearing the flag between two expiries prevents the reset. A clear written in the same cycle as an expiring tick counts as happening first, so that expiry counts as a first expiry.
- R9: The period register holds the low `CNT_W` bits written to it. A new value takes effect only at the next reload.
- R10: Reads of unmapped addresses return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-enable pulse; one counter step per high cycle |
| kick_i | input | 1 | Keepalive: reload the counter and clear the flag |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid in the same cycle as the address |
| smi_req_o | output | 1 | One-cycle interrupt request on a first expiry |
| sys_rst_o | output | 1 | One-cycle reset request on a second expiry |

## Verification
The bench counts ticks around each boundary:
- max(P,1)−1 ticks must leave the flag clear, and one more must set it. A design that is off by one either expires early or needs an extra tick.
- An acknowledge written in the same cycle as the expiring tick must count as a first expiry. A design that lets the set win would hold a stale flag and reset one period too soon.
- A kick that coincides with a tick must suppress the expiry.
- A period rewritten in the middle of a count must not shorten that count.
- With the interrupt disabled, the flag must still be set, and the status write must clear only on bit 3, so a design that decodes the wrong bit or clears on any write is caught.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

   localparam logic [7:0] PM_SMI_CTL_OFS = 8'h30;
   localparam logic [7:0] TMR_BASE_OFS   = 8'h60;
   localparam logic [7:0] TMR_STATUS_OFS = 8'h04;
   localparam logic [7:0] TMR_PERIOD_OFS = 8'h08;

   localparam logic [7:0] ADDR_SMI_CTL = PM_SMI_CTL_OFS;
   localparam logic [7:0] ADDR_STATUS  = TMR_BASE_OFS + TMR_STATUS_OFS;
   localparam logic [7:0] ADDR_PERIOD  = TMR_BASE_OFS + TMR_PERIOD_OFS;

   localparam int unsigned SMI_EN_BIT   = 13;
   localparam int unsigned EXP_FLAG_BIT = 3;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_SMI_CTL,
      SEL_STATUS,
      SEL_PERIOD
   } wdt2_sel_e;

endpackage

// File: rtl/wdt2_regs.sv
module wdt2_regs
   import wdt2_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned PERIOD_RST = 1000,
   parameter bit          SMI_EN_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              flag_i,
   output logic              smi_en_o,
   output logic [CNT_W-1:0]  period_o,
   output logic              flag_clr_o
);

   localparam logic [ADDR_W-1:0] A_SMI    = ADDR_W'(ADDR_SMI_CTL);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);
   localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(ADDR_PERIOD);
   localparam logic [CNT_W-1:0]  PER_INIT = CNT_W'(PERIOD_RST);

   wdt2_sel_e        sel;
   logic             wr_en;
   logic             smi_en_q;
   logic [CNT_W-1:0] period_q;

   always_comb begin
      unique case (addr_i)
         A_SMI:    sel = SEL_SMI_CTL;
         A_STATUS: sel = SEL_STATUS;
         A_PERIOD: sel = SEL_PERIOD;
         default:  sel = SEL_NONE;
      endcase
   end

   assign wr_en = req_i & we_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smi_en_q <= SMI_EN_RST;
         period_q <= PER_INIT;
      end else if (wr_en) begin
         if (sel == SEL_SMI_CTL) smi_en_q <= wdata_i[SMI_EN_BIT];
         if (sel == SEL_PERIOD)  period_q <= wdata_i[CNT_W-1:0];
      end
   end

   assign flag_clr_o = wr_en && (sel == SEL_STATUS) && wdata_i[EXP_FLAG_BIT];
   assign smi_en_o   = smi_en_q;
   assign period_o   = period_q;

   always_comb begin
      rdata_o = '0;
      if (req_i && !we_i) begin
         unique case (sel)
            SEL_SMI_CTL: rdata_o[SMI_EN_BIT]   = smi_en_q;
            SEL_STATUS:  rdata_o[EXP_FLAG_BIT] = flag_i;
            SEL_PERIOD:  rdata_o[CNT_W-1:0]    = period_q;
            default:     rdata_o = '0;
         endcase
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata_i;

   // R10: a write to an unmapped address leaves both registers unchanged
   a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_NONE) |=> ($stable(smi_en_q) && $stable(period_q)));

endmodule

// File: rtl/wdt2_countdown.sv
module wdt2_countdown #(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned PERIOD_RST = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             reload_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             expire_o
);

   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_INIT = (PERIOD_RST == 0) ? ONE : CNT_W'(PERIOD_RST);

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] load_val;
   logic             last_step;

   assign load_val  = (period_i == '0) ? ONE : period_i;
   assign last_step = (count_q <= ONE);
   assign expire_o  = tick_i & ~reload_i & last_step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    count_q <= CNT_INIT;
      else if (reload_i || expire_o) count_q <= load_val;
      else if (tick_i)               count_q <= count_q - ONE;
   end

   // R2: the count never sits at zero
   a_r2_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      count_q != '0);
   // R2: with no tick and no reload the count holds
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !reload_i) |=> $stable(count_q));
   // R7: a reload never coincides with an expiry
   a_r7_kick_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      reload_i |-> !expire_o);

endmodule

// File: rtl/wdt2_escalate.sv
module wdt2_escalate (
   input  logic clk,
   input  logic rst_n,
   input  logic expire_i,
   input  logic clear_i,
   input  logic smi_en_i,
   output logic flag_o,
   output logic smi_o,
   output logic sysrst_o
);

   logic flag_q, smi_q, rst_q;
   logic flag_live;

   // A clear in the same cycle is applied before the expiry is judged
   assign flag_live = flag_q & ~clear_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         smi_q  <= 1'b0;
         rst_q  <= 1'b0;
      end else begin
         smi_q <= 1'b0;
         rst_q <= 1'b0;
         if (expire_i) begin
            if (flag_live) begin
               rst_q  <= 1'b1;
               flag_q <= 1'b0;
            end else begin
               flag_q <= 1'b1;
               smi_q  <= smi_en_i;
            end
         end else begin
            flag_q <= flag_live;
         end
      end
   end

   assign flag_o   = flag_q;
   assign smi_o    = smi_q;
   assign sysrst_o = rst_q;

   a_r4_smi_single: assert property (@(posedge clk) disable iff (!rst_n)
      smi_q |=> !smi_q);
   a_r4_smi_gated: assert property (@(posedge clk) disable iff (!rst_n)
      smi_q |-> $past(smi_en_i));
   a_r3_smi_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
      smi_q |-> flag_q);
   a_r5_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |=> !rst_q);
   a_r5_rst_after_flag: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |-> ($past(flag_q) && !flag_q));
   a_r5_no_smi_on_rst: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_q && smi_q));

endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned PERIOD_RST = 1000,
   parameter bit          SMI_EN_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              kick_i,
   input  logic              bus_req_i,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              smi_req_o,
   output logic              sys_rst_o
);

   localparam int unsigned MIN_DATA_W = wdt2_pkg::SMI_EN_BIT + 1;

   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end
   if (DATA_W < MIN_DATA_W || CNT_W > DATA_W) begin : g_bad_data
      $error("DATA_W must hold the enable bit and the period");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W out of range");
   end
   if (PERIOD_RST >= (64'd1 << CNT_W)) begin : g_bad_period
      $error("PERIOD_RST does not fit CNT_W");
   end

   logic             flag;
   logic             smi_en;
   logic [CNT_W-1:0] period;
   logic             flag_clr_w;
   logic             expire;

   wdt2_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .PERIOD_RST(PERIOD_RST), .SMI_EN_RST(SMI_EN_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .req_i(bus_req_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
      .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
      .flag_i(flag), .smi_en_o(smi_en), .period_o(period),
      .flag_clr_o(flag_clr_w)
   );

   wdt2_countdown #(.CNT_W(CNT_W), .PERIOD_RST(PERIOD_RST)) u_count (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .reload_i(kick_i),
      .period_i(period), .expire_o(expire)
   );

   wdt2_escalate u_esc (
      .clk(clk), .rst_n(rst_n), .expire_i(expire),
      .clear_i(flag_clr_w | kick_i), .smi_en_i(smi_en),
      .flag_o(flag), .smi_o(smi_req_o), .sysrst_o(sys_rst_o)
   );

   // R7: a kick leaves the flag clear on the next cycle
   a_r7_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
      kick_i |=> !flag);

endmodule

// File: tb/twostage_wdt_tb_top.sv
module twostage_wdt_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_SMI = 8'h30, A_STS = 8'h64, A_PER = 8'h68, A_NONE = 8'h40;

   logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0, kick_i = 1'b0;
   logic bus_req_i = 1'b0, bus_we_i = 1'b0;
   logic [7:0]  bus_addr_i = '0;
   logic [31:0] bus_wdata_i = '0, bus_rdata_o;
   logic smi_req_o, sys_rst_o;
   int n_chk = 0, n_fail = 0, smi_seen = 0, rst_seen = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   twostage_wdt dut_i (.*);

   always @(negedge clk) begin
      if (smi_req_o) smi_seen++;
      if (sys_rst_o) rst_seen++;
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_req_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
      @(negedge clk);
      bus_req_i = 0; bus_we_i = 0; #1;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      bus_req_i = 1; bus_we_i = 0; bus_addr_i = a; #1;
      d = bus_rdata_o;
      bus_req_i = 0; #1;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_i = 1;
         @(negedge clk); tick_i = 0;
      end
      #1;
   endtask

   task automatic kick();
      @(negedge clk); kick_i = 1;
      @(negedge clk); kick_i = 0; #1;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(A_STS, d); chk("R1 status", d, 0);
      rd(A_SMI, d); chk("R1 smi ctl", d, 32'h2000);
      rd(A_PER, d); chk("R1 period", d, 1000);
      chk("R1 outputs", {smi_req_o, sys_rst_o}, 0);
   endtask

   task automatic t_first_expiry();
      logic [31:0] d; int s0;
      wr(A_PER, 5); kick(); s0 = smi_seen;
      ticks(4);
      repeat (5) @(negedge clk); #1;
      rd(A_STS, d); chk("R2 no expiry after P-1 ticks and idle", d, 0);
      ticks(1);
      rd(A_STS, d); chk("R3 flag after P ticks", d, 8);
      chk("R4 smi pulse count", smi_seen - s0, 1);
   endtask

   task automatic t_second_expiry();
      logic [31:0] d; int s0, r0;
      s0 = smi_seen; r0 = rst_seen;
      ticks(4);
      chk("R5 no reset early", rst_seen - r0, 0);
      ticks(1);
      chk("R5 one reset pulse", rst_seen - r0, 1);
      chk("R5 no smi on reset", smi_seen - s0, 0);
      rd(A_STS, d); chk("R5 flag cleared by reset", d, 0);
   endtask

   task automatic t_smi_off_w1c();
      logic [31:0] d; int s0;
      wr(A_SMI, 0); kick(); s0 = smi_seen;
      ticks(5);
      rd(A_STS, d); chk("R4 flag set with smi off", d, 8);
      chk("R4 no smi when disabled", smi_seen - s0, 0);
      wr(A_STS, 0);
      rd(A_STS, d); chk("R6 zero write ignored", d, 8);
      wr(A_STS, 32'hFFFF_FFF7);
      rd(A_STS, d); chk("R6 other bits ignored, read zero", d, 8);
      wr(A_STS, 8);
      rd(A_STS, d); chk("R6 w1c clears", d, 0);
      wr(A_SMI, 32'h2000);
   endtask

   task automatic t_fw_clear();
      logic [31:0] d; int s0, r0;
      kick(); r0 = rst_seen;
      ticks(5); wr(A_STS, 8); ticks(5);
      rd(A_STS, d); chk("R8 cleared between expiries: flag again", d, 8);
      chk("R8 no reset after clear", rst_seen - r0, 0);
      s0 = smi_seen;
      ticks(4);
      @(negedge clk);
      tick_i = 1; bus_req_i = 1; bus_we_i = 1; bus_addr_i = A_STS; bus_wdata_i = 8;
      @(negedge clk);
      tick_i = 0; bus_req_i = 0; bus_we_i = 0; #1;
      chk("R8 coincident clear: no reset", rst_seen - r0, 0);
      chk("R8 coincident clear: first-expiry smi", smi_seen - s0, 1);
      rd(A_STS, d); chk("R8 coincident clear: flag set", d, 8);
   endtask

   task automatic t_kick();
      logic [31:0] d;
      kick();
      rd(A_STS, d); chk("R7 kick clears flag", d, 0);
      ticks(4);
      @(negedge clk); tick_i = 1; kick_i = 1;
      @(negedge clk); tick_i = 0; kick_i = 0; #1;
      rd(A_STS, d); chk("R7 kick beats tick", d, 0);
      ticks(4);
      rd(A_STS, d); chk("R7 reloaded count not yet expired", d, 0);
      ticks(1);
      rd(A_STS, d); chk("R7 expiry after full reload", d, 8);
   endtask

   task automatic t_period_change();
      logic [31:0] d;
      kick(); ticks(2); wr(A_PER, 3); ticks(2);
      rd(A_STS, d); chk("R9 old period still running", d, 0);
      ticks(1);
      rd(A_STS, d); chk("R9 expiry on old period", d, 8);
      wr(A_STS, 8); ticks(2);
      rd(A_STS, d); chk("R9 new period not yet", d, 0);
      ticks(1);
      rd(A_STS, d); chk("R9 new period expiry", d, 8);
      rd(A_PER, d); chk("R9 period readback", d, 3);
      wr(A_PER, 32'hABCD_0000 | 32'h0); kick();
      rd(A_PER, d); chk("R9 upper bits dropped", d, 0);
      ticks(1);
      rd(A_STS, d); chk("R2 zero period acts as one", d, 8);
      wr(A_PER, 5); kick();
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      wr(A_NONE, 32'hFFFF_FFFF);
      rd(A_NONE, d); chk("R10 unmapped reads zero", d, 0);
      rd(A_PER, d);  chk("R10 period untouched", d, 5);
      rd(A_SMI, d);  chk("R10 smi ctl untouched", d, 32'h2000);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1; #1;
      t_reset();
      t_first_expiry();
      t_second_expiry();
      t_smi_off_w1c();
      t_fw_clear();
      t_kick();
      t_period_change();
      t_unmapped();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule